// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit-Manipulation Unit

This block executes the second-byte instruction group of an 8-bit processor on a single operand. A decoded opcode byte selects a shift or rotate kind, a bit test, a bit clear or a bit set, together with one of eight operand slots. One of those slots is the memory location addressed by the HL pair. The datapath is combinational. From the opcode, the operand and the incoming flags it produces the result, the new flags, a write-back enable and an indication of whether a memory operand needs a store phase. Fetching and storing the operand are left to the surrounding core. The same datapath also serves the short accumulator-only rotate instructions when the `acc_form` input is high.

A small phase sequencer runs beside the datapath. It tells the core which bus phase is due when a memory-slot instruction is issued. The states are `PH_IDLE`, `PH_LOAD`, `PH_EXEC` and `PH_STORE`, and the transitions are:

- `PH_IDLE` goes to `PH_LOAD` on `issue` when the slot is memory.
- `PH_LOAD` always goes to `PH_EXEC`.
- `PH_EXEC` goes to `PH_STORE` when a store is needed. For a bit test it goes back to `PH_IDLE` instead.
- `PH_STORE` always goes to `PH_IDLE`.

A register-slot issue leaves the sequencer in `PH_IDLE`. In `PH_IDLE`, `issue` with a register slot causes no transition.

Top module: `pfx_unit`

## Requirements
- R1: Kind 2 (RL) shifts left, puts carry-in at bit 0 and moves bit 7 to carry. Kind 3 (RR) shifts right, puts carry-in at bit 7 and moves bit 0 to carry. Carry-in is `flags_in[0]`.
- R2: Kind 0 (RLC) copies bit 7 into both bit 0 and carry. Kind 1 (RRC) copies bit 0 into both bit 7 and carry.
- R3: Kind 4 (SLA) moves bit 7 to carry and fills bit 0 with 0. Kind 5 (SRA) keeps bit 7 and moves bit 0 to carry. Kind 7 (SRL) fills bit 7 with 0 and moves bit 0 to carry.
- R4: Kind 6 (SWAP) exchanges the two nibbles and clears carry.
- R5: For every shift, rotate or swap (opcode bits 7:6 = 00), zero is set exactly when the result is 0, N and H are cleared, and `wb_en` is 1. The flag vector is {Z,N,H,C} at bits 3,2,1,0.
- R6: A bit test (bits 7:6 = 01) on the bit indexed by bits 5:3 behaves as follows. Z is set when that bit is 0, N is cleared, H is set, C keeps `flags_in[0]`, `result` equals the operand, and `wb_en` and `store_needed` are 0.
- R7: A bit clear (10) or bit set (11) clears or sets the indexed bit, leaves the other bits as they are, passes `flags_in` through unchanged, and drives `wb_en` to 1.
- R8: Opcode bits 2:0 appear on `slot` (0..7 = B,C,D,E,H,L,memory,A). `mem_op` is 1 only for slot 6. `store_needed` is `mem_op` and not a bit test.
- R9: With `acc_form` high, kinds 0..3 produce the same result and carry as R1/R2. Z is forced to 0, N and H are 0, and `mem_op` is 0 whatever bits 2:0 hold.
- R10: A memory issue with a store runs `PH_LOAD` (`rd_req`=1), then `PH_EXEC`, then `PH_STORE` (`wr_req`=1), then `PH_IDLE`, one cycle each, starting the cycle after the issue edge.
- R11: A memory bit test runs `PH_LOAD`, then `PH_EXEC`, then returns to `PH_IDLE` and never asserts `wr_req`.
- R12: A register-slot issue leaves `busy`, `rd_req` and `wr_req` at 0. An `issue` while `busy` is 1 does not change the sequence.
- R13: After reset the sequencer is in `PH_IDLE`, with `busy`, `rd_req` and `wr_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Start of an instruction (sampled in idle) |
| opcode | input | 8 | Second opcode byte |
| acc_form | input | 1 | Selects accumulator-only rotate behaviour |
| operand | input | 8 | Operand value (register or loaded byte) |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| result | output | 8 | Computed operand value |
| flags_out | output | 4 | Updated flags {Z,N,H,C} |
| wb_en | output | 1 | Result is to be written back |
| slot | output | 3 | Operand slot selected by the opcode |
| mem_op | output | 1 | Operand is the memory slot |
| store_needed | output | 1 | Memory operand needs a store phase |
| rd_req | output | 1 | Load phase is active |
| wr_req | output | 1 | Store phase is active |
| busy | output | 1 | Sequencer is not idle |

## Verification
The assertions assume the following about the inputs:
- `opcode` and `acc_form` stay stable while `busy` is high, so that the live `store_needed` agrees with the decision latched at issue.
- `acc_form` is only raised together with the rotate kinds 0..3.

The directed tasks hold the opcode from the issue edge until the sequence has ended. They raise `acc_form` only with RLC, RRC, RL or RR opcodes. They drop `issue` before the idle cycle that follows a finished sequence.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int DW    = 8;
    localparam int FW    = 4;
    localparam int SEL_W = 3;
    localparam int HALF  = DW / 2;

    localparam int F_Z = 3;
    localparam int F_N = 2;
    localparam int F_H = 1;
    localparam int F_C = 0;

    localparam logic [SEL_W-1:0] SLOT_MEM = 3'd6;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'b00,
        GRP_TEST  = 2'b01,
        GRP_CLR   = 2'b10,
        GRP_SET   = 2'b11
    } grp_e;

    typedef enum logic [2:0] {
        SK_RLC  = 3'd0,
        SK_RRC  = 3'd1,
        SK_RL   = 3'd2,
        SK_RR   = 3'd3,
        SK_SLA  = 3'd4,
        SK_SRA  = 3'd5,
        SK_SWAP = 3'd6,
        SK_SRL  = 3'd7
    } shk_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_EXEC  = 2'd2,
        PH_STORE = 2'd3
    } ph_e;
endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
    import pfx_pkg::*;
(
    input  logic [DW-1:0]    opcode,
    input  logic             acc_form,
    output grp_e             grp,
    output shk_e             kind,
    output logic [SEL_W-1:0] bidx,
    output logic [SEL_W-1:0] slot,
    output logic             mem_op
);
    always_comb begin
        slot = opcode[2:0];
        bidx = opcode[5:3];
        kind = shk_e'(opcode[5:3]);
        if (acc_form) begin
            grp    = GRP_SHIFT;
            mem_op = 1'b0;
        end else begin
            grp    = grp_e'(opcode[7:6]);
            mem_op = (opcode[2:0] == SLOT_MEM);
        end
    end
endmodule

// File: rtl/pfx_shifter.sv
module pfx_shifter
    import pfx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  shk_e         kind,
    output logic [W-1:0] y,
    output logic         cout
);
    localparam int H = W / 2;

    always_comb begin
        unique case (kind)
            SK_RLC: begin
                y    = {a[W-2:0], a[W-1]};
                cout = a[W-1];
            end
            SK_RRC: begin
                y    = {a[0], a[W-1:1]};
                cout = a[0];
            end
            SK_RL: begin
                y    = {a[W-2:0], cin};
                cout = a[W-1];
            end
            SK_RR: begin
                y    = {cin, a[W-1:1]};
                cout = a[0];
            end
            SK_SLA: begin
                y    = {a[W-2:0], 1'b0};
                cout = a[W-1];
            end
            SK_SRA: begin
                y    = {a[W-1], a[W-1:1]};
                cout = a[0];
            end
            SK_SWAP: begin
                y    = {a[H-1:0], a[W-1:H]};
                cout = 1'b0;
            end
            SK_SRL: begin
                y    = {1'b0, a[W-1:1]};
                cout = a[0];
            end
        endcase
    end
endmodule

// File: rtl/pfx_bitop.sv
module pfx_bitop
    import pfx_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0]     a,
    input  logic [SEL_W-1:0] bidx,
    input  grp_e             grp,
    output logic [W-1:0]     y,
    output logic             sel_bit
);
    logic [W-1:0] mask;

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (bidx == SEL_W'(i));
    end

    assign sel_bit = |(a & mask);

    always_comb begin
        unique case (grp)
            GRP_SET:   y = a | mask;
            GRP_CLR:   y = a & ~mask;
            GRP_TEST,
            GRP_SHIFT: y = a;
        endcase
    end
endmodule

// File: rtl/pfx_sequencer.sv
module pfx_sequencer
    import pfx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic mem_op,
    input  logic store_needed,
    output logic rd_req,
    output logic wr_req,
    output logic busy
);
    ph_e  ph_q, ph_d;
    logic keep_store_q;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:  if (issue && mem_op) ph_d = PH_LOAD;
            PH_LOAD:  ph_d = PH_EXEC;
            PH_EXEC:  ph_d = keep_store_q ? PH_STORE : PH_IDLE;
            PH_STORE: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q         <= PH_IDLE;
            keep_store_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (ph_q == PH_IDLE && issue && mem_op)
                keep_store_q <= store_needed;
        end
    end

    always_comb begin
        rd_req = 1'b0;
        wr_req = 1'b0;
        busy   = 1'b1;
        unique case (ph_q)
            PH_IDLE:  busy   = 1'b0;
            PH_LOAD:  rd_req = 1'b1;
            PH_EXEC:  ;
            PH_STORE: wr_req = 1'b1;
        endcase
    end
endmodule

// File: rtl/pfx_unit.sv
module pfx_unit
    import pfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [DW-1:0]    opcode,
    input  logic             acc_form,
    input  logic [DW-1:0]    operand,
    input  logic [FW-1:0]    flags_in,
    output logic [DW-1:0]    result,
    output logic [FW-1:0]    flags_out,
    output logic             wb_en,
    output logic [SEL_W-1:0] slot,
    output logic             mem_op,
    output logic             store_needed,
    output logic             rd_req,
    output logic             wr_req,
    output logic             busy
);
    grp_e             grp;
    shk_e             kind;
    logic [SEL_W-1:0] bidx;
    logic [DW-1:0]    sh_y, bo_y;
    logic             sh_c, sel_bit;

    pfx_decode u_dec (
        .opcode   (opcode),
        .acc_form (acc_form),
        .grp      (grp),
        .kind     (kind),
        .bidx     (bidx),
        .slot     (slot),
        .mem_op   (mem_op)
    );

    pfx_shifter #(.W(DW)) u_sh (
        .a    (operand),
        .cin  (flags_in[F_C]),
        .kind (kind),
        .y    (sh_y),
        .cout (sh_c)
    );

    pfx_bitop #(.W(DW)) u_bo (
        .a       (operand),
        .bidx    (bidx),
        .grp     (grp),
        .y       (bo_y),
        .sel_bit (sel_bit)
    );

    always_comb begin
        flags_out = flags_in;
        wb_en     = 1'b1;
        unique case (grp)
            GRP_SHIFT: begin
                result         = sh_y;
                flags_out[F_Z] = (sh_y == '0) && !acc_form;
                flags_out[F_N] = 1'b0;
                flags_out[F_H] = 1'b0;
                flags_out[F_C] = sh_c;
            end
            GRP_TEST: begin
                result         = bo_y;
                wb_en          = 1'b0;
                flags_out[F_Z] = !sel_bit;
                flags_out[F_N] = 1'b0;
                flags_out[F_H] = 1'b1;
            end
            GRP_CLR,
            GRP_SET: result = bo_y;
        endcase
    end

    assign store_needed = mem_op && wb_en;

    pfx_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue        (issue),
        .mem_op       (mem_op),
        .store_needed (store_needed),
        .rd_req       (rd_req),
        .wr_req       (wr_req),
        .busy         (busy)
    );
endmodule

// File: rtl/pfx_unit_chk.sv
module pfx_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       issue,
    input logic [7:0] opcode,
    input logic       acc_form,
    input logic [7:0] operand,
    input logic [3:0] flags_in,
    input logic [7:0] result,
    input logic [3:0] flags_out,
    input logic       wb_en,
    input logic       mem_op,
    input logic       store_needed,
    input logic       rd_req,
    input logic       wr_req,
    input logic       busy
);
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !wr_req));

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    a_r10_load_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (busy && !rd_req && !wr_req));

    a_r10_store_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !busy);

    a_r12_reg_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !busy && !mem_op) |=> !busy);

    a_r11_test_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_form && opcode[7:6] == 2'b01) |->
            (!wb_en && !store_needed && result == operand && flags_out[1] && !flags_out[2]
             && flags_out[0] == flags_in[0]));

    a_r7_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_form && opcode[7]) |-> (wb_en && flags_out == flags_in));

    a_r5_nh_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[7:6] == 2'b00 || acc_form) |-> (flags_out[2:1] == 2'b00 && wb_en));

    a_r9_acc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc_form |-> (!flags_out[3] && !mem_op));
endmodule

bind pfx_unit pfx_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue        (issue),
    .opcode       (opcode),
    .acc_form     (acc_form),
    .operand      (operand),
    .flags_in     (flags_in),
    .result       (result),
    .flags_out    (flags_out),
    .wb_en        (wb_en),
    .mem_op       (mem_op),
    .store_needed (store_needed),
    .rd_req       (rd_req),
    .wr_req       (wr_req),
    .busy         (busy)
);

// File: tb/sim_pfx_unit.sv
module sim_pfx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic       acc_form = 1'b0;
    logic [7:0] operand = 8'h00;
    logic [3:0] flags_in = 4'h0;
    logic [7:0] result;
    logic [3:0] flags_out;
    logic       wb_en;
    logic [2:0] slot;
    logic       mem_op, store_needed, rd_req, wr_req, busy;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    pfx_unit u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .acc_form(acc_form), .operand(operand), .flags_in(flags_in),
        .result(result), .flags_out(flags_out), .wb_en(wb_en), .slot(slot),
        .mem_op(mem_op), .store_needed(store_needed), .rd_req(rd_req),
        .wr_req(wr_req), .busy(busy)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] op, input logic [7:0] a,
                         input logic [3:0] fl, input logic acc);
        opcode = op; operand = a; flags_in = fl; acc_form = acc;
        #1;
    endtask

    // expected: {result, flags, wb_en}
    task automatic alu(input string tag, input logic [7:0] op, input logic [7:0] a,
                       input logic [3:0] fl, input logic acc,
                       input logic [7:0] er, input logic [3:0] ef, input logic ew);
        drive(op, a, fl, acc);
        chk(tag, {3'b0, result, flags_out, wb_en}, {3'b0, er, ef, ew});
    endtask

    task automatic t_reset;
        chk("R13 reset idle", {13'b0, busy, rd_req, wr_req}, 16'h0);
    endtask

    task automatic t_carry_rotates;
        alu("R1 RL cin0", 8'h10, 8'h85, 4'h0, 1'b0, 8'h0A, 4'b0001, 1'b1);
        alu("R1 RL cin1", 8'h10, 8'h85, 4'h1, 1'b0, 8'h0B, 4'b0001, 1'b1);
        alu("R1 RR zero", 8'h18, 8'h01, 4'h0, 1'b0, 8'h00, 4'b1001, 1'b1);
        alu("R1 RR cin1", 8'h18, 8'h01, 4'h1, 1'b0, 8'h80, 4'b0001, 1'b1);
    endtask

    task automatic t_circular;
        alu("R2 RLC", 8'h00, 8'h80, 4'h0, 1'b0, 8'h01, 4'b0001, 1'b1);
        alu("R2 RRC", 8'h09, 8'h01, 4'h0, 1'b0, 8'h80, 4'b0001, 1'b1);
        alu("R2 RLC no carry", 8'h01, 8'h42, 4'h1, 1'b0, 8'h84, 4'b0000, 1'b1);
    endtask

    task automatic t_shifts;
        alu("R3 SLA", 8'h20, 8'h81, 4'h0, 1'b0, 8'h02, 4'b0001, 1'b1);
        alu("R3 SLA zero", 8'h20, 8'h80, 4'h0, 1'b0, 8'h00, 4'b1001, 1'b1);
        alu("R3 SRA", 8'h28, 8'h81, 4'h0, 1'b0, 8'hC0, 4'b0001, 1'b1);
        alu("R3 SRL", 8'h38, 8'h81, 4'h1, 1'b0, 8'h40, 4'b0001, 1'b1);
    endtask

    task automatic t_swap;
        alu("R4 SWAP", 8'h30, 8'hA5, 4'hF, 1'b0, 8'h5A, 4'b0000, 1'b1);
        alu("R5 SWAP zero", 8'h37, 8'h00, 4'h7, 1'b0, 8'h00, 4'b1000, 1'b1);
    endtask

    task automatic t_test;
        alu("R6 BIT set", 8'h58, 8'h08, 4'b1101, 1'b0, 8'h08, 4'b0011, 1'b0);
        alu("R6 BIT clear", 8'h58, 8'hF7, 4'b0100, 1'b0, 8'hF7, 4'b1010, 1'b0);
        drive(8'h7E, 8'h80, 4'h0, 1'b0);
        chk("R6 BIT mem no store", {14'b0, mem_op, store_needed}, 16'h2);
    endtask

    task automatic t_clr_set;
        alu("R7 RES", 8'hBF, 8'hFF, 4'b1010, 1'b0, 8'h7F, 4'b1010, 1'b1);
        alu("R7 SET", 8'hC6, 8'h00, 4'b0101, 1'b0, 8'h01, 4'b0101, 1'b1);
        for (int b = 0; b < 8; b++) begin
            for (int v = 0; v < 256; v += 37) begin
                drive(8'h80 | 8'(b << 3), 8'(v), 4'h0, 1'b0);
                chk("R7 RES sweep", {8'h0, result}, {8'h0, 8'(v) & ~(8'h01 << b)});
                drive(8'hC0 | 8'(b << 3), 8'(v), 4'h0, 1'b0);
                chk("R7 SET sweep", {8'h0, result}, {8'h0, 8'(v) | (8'h01 << b)});
            end
        end
    endtask

    task automatic t_slots;
        drive(8'h15, 8'h00, 4'h0, 1'b0);
        chk("R8 slot L", {12'b0, slot, mem_op}, {12'b0, 3'd5, 1'b0});
        drive(8'hC6, 8'h00, 4'h0, 1'b0);
        chk("R8 slot mem", {12'b0, slot, mem_op}, {12'b0, 3'd6, 1'b1});
        chk("R8 store needed", {15'b0, store_needed}, 16'h1);
        drive(8'h06, 8'h00, 4'h0, 1'b0);
        chk("R8 slot mem shift", {15'b0, store_needed}, 16'h1);
    endtask

    task automatic t_acc;
        alu("R9 acc RL zero forced", 8'h10, 8'h80, 4'h0, 1'b1, 8'h00, 4'b0001, 1'b1);
        alu("R9 acc RRC", 8'h0F, 8'h01, 4'h0, 1'b1, 8'h80, 4'b0001, 1'b1);
        drive(8'h06, 8'h00, 4'h0, 1'b1);
        chk("R9 acc no mem", {7'b0, mem_op, result, 4'h0}, {7'b0, 1'b0, 8'h00, 4'h0});
        chk("R9 acc flags", {12'b0, flags_out}, 16'h0);
    endtask

    // sample: {busy, rd, wr}
    function automatic logic [15:0] st();
        return {13'b0, busy, rd_req, wr_req};
    endfunction

    task automatic t_mem_store;
        @(negedge clk);
        drive(8'hC6, 8'h00, 4'h0, 1'b0);
        issue = 1'b1;
        @(negedge clk); issue = 1'b0;
        chk("R10 load phase", st(), 16'b110);
        @(negedge clk);
        chk("R10 exec phase", st(), 16'b100);
        @(negedge clk);
        chk("R10 store phase", st(), 16'b101);
        @(negedge clk);
        chk("R10 back idle", st(), 16'b000);
    endtask

    task automatic t_mem_test;
        @(negedge clk);
        drive(8'h46, 8'h00, 4'h0, 1'b0);
        issue = 1'b1;
        @(negedge clk); issue = 1'b0;
        chk("R11 load phase", st(), 16'b110);
        @(negedge clk);
        chk("R11 exec phase", st(), 16'b100);
        @(negedge clk);
        chk("R11 no store", st(), 16'b000);
        @(negedge clk);
        chk("R11 stays idle", st(), 16'b000);
    endtask

    task automatic t_reg_and_busy;
        @(negedge clk);
        drive(8'h10, 8'h01, 4'h0, 1'b0);
        issue = 1'b1;
        @(negedge clk); issue = 1'b0;
        chk("R12 register issue idle", st(), 16'b000);
        drive(8'h1E, 8'h01, 4'h0, 1'b0);
        issue = 1'b1;
        @(negedge clk);
        chk("R12 busy load", st(), 16'b110);
        @(negedge clk);
        chk("R12 issue ignored exec", st(), 16'b100);
        @(negedge clk);
        chk("R12 issue ignored store", st(), 16'b101);
        issue = 1'b0;
        @(negedge clk);
        chk("R12 idle after", st(), 16'b000);
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_carry_rotates();
        t_circular();
        t_shifts();
        t_swap();
        t_test();
        t_clr_set();
        t_slots();
        t_acc();
        t_mem_store();
        t_mem_test();
        t_reg_and_busy();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule